// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers interrupt requests from a parameterised set of internal peripheral lines and from five external lines. External line 0 is reserved as the fast interrupt line and drives only the fast request output. Every other line is a normal source. Each normal source has an enable bit and a 3-bit priority, which gives eight levels. The controller registers a normal interrupt request to the processor whenever the best enabled pending source outranks the level now being serviced.

Software reads the current-vector register to obtain the 32-bit handler address of the winning source. That read also pushes the winner's level onto an internal nesting stack. A write to the end-of-interrupt register pops the stack and restores the previous level. External normal lines can be level-sensitive or edge-triggered. An edge-triggered line holds its request until its vector is read. A programmable spurious vector is returned when software reads the current-vector register while nothing is pending.

Source numbering: internal lines take sources 0..N_INT-1, and external lines 1..N_EXT-1 take sources N_INT upwards. With the defaults, external lines 1 to 4 are sources 8 to 11. Register word addresses: per-source control at 0x00+n, per-source vector at 0x20+n, current vector 0x40, end-of-interrupt 0x41, pending status 0x42, spurious vector 0x43, fast vector 0x44, fast control 0x45. Read data appears one cycle after the read strobe, qualified by a valid pulse. Inputs pass through one synchronising register, and edge latches add one more.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Synchronous active-high reset clears both request outputs, the read-valid output, all enables and the nesting stack.
- R2: The normal request output rises when an enabled normal source is pending and the stack is empty; a pending but disabled source raises nothing.
- R3: A read of the current-vector register (0x40) returns the vector stored at 0x20+n for the pending enabled source n with the highest priority.
- R4: When pending enabled sources share the highest priority, the lower source number wins.
- R5: After a current-vector read, the normal request stays low while only levels equal to or below the pushed level are pending, and it rises again when a strictly higher level is pending (nesting).
- R6: A write to the end-of-interrupt register (0x41) pops one level; a write with an empty stack leaves it empty.
- R7: A current-vector read with no enabled source pending returns the spurious vector (0x43) and pushes nothing, so a pending priority-0 source still raises the request afterwards.
- R8: A level-mode line follows its input. An edge-mode external line latches a rising edge and keeps it pending until its vector is read, and then stays clear.
- R9: The fast line (external line 0) drives only the fast request output, bypassing the priority scheme, when enabled (0x45 bit 0), either level or edge mode (0x45 bit 8). A read of the fast vector (0x44) returns that vector and clears a latched fast edge.
- R10: The control word of source n at 0x00+n reads back as enable in bit 0, priority in bits 6:4 and edge mode in bit 8, where the edge bit is kept only for external sources.
- R11: The pending status register (0x42) shows raw pending normal source n in bit n, before enables, and the pending fast line in bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_src_i | input | N_INT | Internal peripheral request lines, level-sensitive |
| ext_src_i | input | N_EXT | External lines; bit 0 is the fast line |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted nesting stack shows up as a wrong normal request level within two cycles of the next pending change. It appears either as a request that never returns after an end-of-interrupt or as one that fires for an equal level. A wrong arbitration choice or a stale edge latch shows up on the first current-vector read, as the wrong handler address or as a request that rises again after acknowledgement. The bench therefore pairs every acknowledgement with a check of the returned vector and a check of the request output a few cycles later.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LVL_W = 3;

  typedef enum logic {RD_WORD, RD_RAM} rd_src_e;

  localparam logic [7:0] A_VEC  = 8'h20;
  localparam logic [7:0] A_CUR  = 8'h40;
  localparam logic [7:0] A_EOI  = 8'h41;
  localparam logic [7:0] A_PEND = 8'h42;
  localparam logic [7:0] A_SPUR = 8'h43;
  localparam logic [7:0] A_FVEC = 8'h44;
  localparam logic [7:0] A_FCFG = 8'h45;
endpackage

// File: rtl/pic_input_stage.sv
module pic_input_stage #(
  parameter int NLINE = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLINE-1:0] raw_i,
  input  logic [NLINE-1:0] edge_mode_i,
  input  logic [NLINE-1:0] clr_i,
  output logic [NLINE-1:0] pend_o
);
  logic [NLINE-1:0] s1, s2, lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
    end
  end

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)                  lat[g] <= 1'b0;
      else if (s1[g] && !s2[g]) lat[g] <= 1'b1;
      else if (clr_i[g])        lat[g] <= 1'b0;
    end
    assign pend_o[g] = edge_mode_i[g] ? lat[g] : s1[g];
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC  = 12,
  parameter int IDX_W = 4,
  parameter int LVL_W = 3
) (
  input  logic [NSRC-1:0]            req_i,
  input  logic [NSRC-1:0][LVL_W-1:0] prio_i,
  output logic                       valid_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [LVL_W-1:0]           lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    // scan downward; ">=" lets a lower index take over an equal level
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i] && (!valid_o || prio_i[i] >= lvl_o)) begin
        valid_o = 1'b1;
        lvl_o   = prio_i[i];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             empty_o,
  output logic [LVL_W-1:0] top_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVL_W-1:0] stk [DEPTH];
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    cm1;

  assign cm1     = cnt - 1'b1;
  assign empty_o = (cnt == '0);
  assign top_o   = stk[cm1[PW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push_i && pop_i) begin
      if (cnt == '0) begin
        stk[0] <= lvl_i;
        cnt    <= CW'(1);
      end else begin
        stk[cm1[PW-1:0]] <= lvl_i;
      end
    end else if (push_i) begin
      if (cnt < CW'(DEPTH)) begin
        stk[cnt[PW-1:0]] <= lvl_i;
        cnt              <= cnt + 1'b1;
      end
    end else if (pop_i && cnt != '0) begin
      cnt <= cm1;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_INT     = 8,
  parameter int N_EXT     = 5,
  parameter int STK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_INT-1:0] int_src_i,
  input  logic [N_EXT-1:0] ext_src_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             rvalid_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int NSRC  = N_INT + N_EXT - 1;
  localparam int NLINE = NSRC + 1;
  localparam int FAST  = NSRC;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VDEP  = 1 << IDX_W;

  // configuration
  logic [NSRC-1:0]            en_q, edg_q;
  logic [NSRC-1:0][LVL_W-1:0] prio_q;
  logic [31:0]                vec_mem [VDEP];
  logic [31:0]                spur_q, fvec_q;
  logic                       fen_q, fedge_q;

  // datapath
  logic [NLINE-1:0] lines, mode, clr, pend;
  logic [NSRC-1:0]  req;
  logic             win_valid, stk_empty;
  logic [IDX_W-1:0] win_idx, ram_idx, sel_idx;
  logic [LVL_W-1:0] win_lvl, stk_top;
  logic             ctrl_hit, vec_hit, cur_rd, push, pop;

  // read path
  logic [31:0] ram_q, rword_d, rword_q, pend_word;
  rd_src_e     rsrc_q;

  assign sel_idx  = addr_i[IDX_W-1:0];
  assign ctrl_hit = (addr_i[7:5] == 3'b000) && (addr_i[4:0] < 5'(NSRC));
  assign vec_hit  = (addr_i[7:5] == A_VEC[7:5]) && (addr_i[4:0] < 5'(NSRC));
  assign cur_rd   = rd_en_i && (addr_i == A_CUR);
  assign push     = cur_rd && win_valid;
  assign pop      = wr_en_i && (addr_i == A_EOI);

  assign lines = {ext_src_i[0], ext_src_i[N_EXT-1:1], int_src_i};
  assign mode  = {fedge_q, edg_q};
  assign req   = pend[NSRC-1:0] & en_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_clr
    assign clr[g] = push && (win_idx == IDX_W'(g));
  end
  assign clr[FAST] = rd_en_i && (addr_i == A_FVEC);

  pic_input_stage #(.NLINE(NLINE)) u_in (
    .clk        (clk),
    .rst        (rst),
    .raw_i      (lines),
    .edge_mode_i(mode),
    .clr_i      (clr),
    .pend_o     (pend)
  );

  pic_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_arb (
    .req_i  (req),
    .prio_i (prio_q),
    .valid_o(win_valid),
    .idx_o  (win_idx),
    .lvl_o  (win_lvl)
  );

  pic_level_stack #(.DEPTH(STK_DEPTH), .LVL_W(LVL_W)) u_stk (
    .clk    (clk),
    .rst    (rst),
    .push_i (push),
    .pop_i  (pop),
    .lvl_i  (win_lvl),
    .empty_o(stk_empty),
    .top_o  (stk_top)
  );

  // per-source control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      edg_q  <= '0;
      prio_q <= '0;
    end else if (wr_en_i && ctrl_hit) begin
      for (int i = 0; i < NSRC; i++) begin
        if (sel_idx == IDX_W'(i)) begin
          en_q[i]   <= wdata_i[0];
          prio_q[i] <= wdata_i[6:4];
          edg_q[i]  <= (i >= N_INT) ? wdata_i[8] : 1'b0;
        end
      end
    end
  end

  // global registers
  always_ff @(posedge clk) begin
    if (rst) begin
      spur_q  <= '0;
      fvec_q  <= '0;
      fen_q   <= 1'b0;
      fedge_q <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_SPUR) spur_q <= wdata_i;
      if (addr_i == A_FVEC) fvec_q <= wdata_i;
      if (addr_i == A_FCFG) begin
        fen_q   <= wdata_i[0];
        fedge_q <= wdata_i[8];
      end
    end
  end

  // vector memory: one write port, one synchronous read port
  assign ram_idx = push ? win_idx : sel_idx;

  always_ff @(posedge clk) begin
    if (wr_en_i && vec_hit) vec_mem[sel_idx] <= wdata_i;
    ram_q <= vec_mem[ram_idx];
  end

  always_comb begin
    pend_word           = '0;
    pend_word[NSRC-1:0] = pend[NSRC-1:0];
    pend_word[31]       = pend[FAST];
  end

  always_comb begin
    rword_d = '0;
    if (ctrl_hit)
      rword_d = {23'b0, edg_q[sel_idx], 1'b0, prio_q[sel_idx], 3'b0, en_q[sel_idx]};
    else begin
      case (addr_i)
        A_CUR:   rword_d = spur_q;
        A_PEND:  rword_d = pend_word;
        A_SPUR:  rword_d = spur_q;
        A_FVEC:  rword_d = fvec_q;
        A_FCFG:  rword_d = {23'b0, fedge_q, 7'b0, fen_q};
        default: rword_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o <= 1'b0;
      rsrc_q   <= RD_WORD;
      rword_q  <= '0;
    end else begin
      rvalid_o <= rd_en_i;
      rsrc_q   <= (push || vec_hit) ? RD_RAM : RD_WORD;
      rword_q  <= rword_d;
    end
  end

  assign rdata_o = (rsrc_q == RD_RAM) ? ram_q : rword_q;

  // request outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= win_valid && (stk_empty || win_lvl > stk_top);
      fiq_o <= fen_q && pend[FAST];
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int NSRC  = 12,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en_i,
  input logic             wr_en_i,
  input logic [7:0]       addr_i,
  input logic             rvalid_o,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             win_valid,
  input logic [IDX_W-1:0] win_idx,
  input logic [NSRC-1:0]  req,
  input logic             stk_empty
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) $past(rst) |-> (!irq_o && !fiq_o));

  // R2
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(win_valid));

  // R3
  win_req_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> req[win_idx]);

  // R6
  eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == 8'h41 && !rd_en_i && stk_empty) |=> stk_empty);

  // R3
  rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> $past(rd_en_i));
endmodule

bind prio_irq_ctrl pic_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en_i  (rd_en_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .rvalid_o (rvalid_o),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .win_valid(win_valid),
  .win_idx  (win_idx),
  .req      (req),
  .stk_empty(stk_empty)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int N_INT = 8;
  localparam int N_EXT = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N_INT-1:0] int_src = '0;
  logic [N_EXT-1:0] ext_src = '0;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             rvalid, irq, fiq;

  int total = 0;
  int bad   = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  prio_irq_ctrl #(.N_INT(N_INT), .N_EXT(N_EXT), .STK_DEPTH(8)) dut (
    .clk(clk), .rst(rst), .int_src_i(int_src), .ext_src_i(ext_src),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [31:0] vec_of(int n);
    return 32'h1000 + 32'(n) * 32'h10;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: queue the expected word, then issue the read
  task automatic reg_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compare each returned word against the queue head
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL unexpected read data actual=%h expected=none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({31'b0, irq}, 32'd0, "R1 irq after reset");
    check({31'b0, fiq}, 32'd0, "R1 fiq after reset");
    check({31'b0, rvalid}, 32'd0, "R1 rvalid after reset");
    rst = 1'b0;

    for (int n = 0; n < 12; n++) reg_wr(8'h20 + 8'(n), vec_of(n));
    reg_wr(8'h43, 32'hDEAD_BEEF);
    reg_wr(8'h44, 32'h0000_0F00);

    // R2: disabled source raises nothing
    int_src[5] = 1'b1;
    settle();
    check({31'b0, irq}, 32'd0, "R2 disabled source");
    reg_rd(8'h42, 32'h0000_0020, "R11 pending before enable");
    reg_wr(8'h03, 32'h21);
    int_src[3] = 1'b1;
    settle();
    check({31'b0, irq}, 32'd1, "R2 enabled source requests");
    reg_rd(8'h42, 32'h0000_0028, "R11 pending two sources");

    // R3: highest priority wins
    reg_wr(8'h05, 32'h61);
    reg_rd(8'h40, vec_of(5), "R3 vector of top source");
    settle();
    check({31'b0, irq}, 32'd0, "R5 lower level held off");

    // R5/R4: equal level does not preempt; tie goes to lower number
    reg_wr(8'h01, 32'h61);
    int_src[1] = 1'b1;
    settle();
    check({31'b0, irq}, 32'd0, "R5 equal level held off");
    reg_wr(8'h41, 32'h0);
    settle();
    check({31'b0, irq}, 32'd1, "R6 request after pop");
    reg_rd(8'h40, vec_of(1), "R4 tie lower number");
    reg_wr(8'h41, 32'h0);
    int_src[1] = 1'b0; int_src[5] = 1'b0;
    settle();
    reg_rd(8'h40, vec_of(3), "R3 remaining source");
    settle();
    check({31'b0, irq}, 32'd0, "R5 after ack of level 2");

    // R5 nesting with external level-mode line 2 (source 9)
    reg_wr(8'h09, 32'h51);
    ext_src[2] = 1'b1;
    settle();
    check({31'b0, irq}, 32'd1, "R5 higher level preempts");
    reg_rd(8'h40, vec_of(9), "R5 nested vector");
    settle();
    check({31'b0, irq}, 32'd0, "R5 nested acked");
    reg_wr(8'h41, 32'h0);
    settle();
    check({31'b0, irq}, 32'd1, "R6 pop restores level 2");
    ext_src[2] = 1'b0;
    settle();
    check({31'b0, irq}, 32'd0, "R8 level line follows input");
    reg_wr(8'h41, 32'h0);
    settle();
    check({31'b0, irq}, 32'd1, "R6 pop to empty");
    int_src[3] = 1'b0;
    settle();
    check({31'b0, irq}, 32'd0, "R8 internal level released");

    // R7: spurious read pushes nothing
    reg_rd(8'h40, 32'hDEAD_BEEF, "R7 spurious vector");
    reg_wr(8'h00, 32'h01);
    int_src[0] = 1'b1;
    settle();
    check({31'b0, irq}, 32'd1, "R7 priority 0 still requests");
    reg_rd(8'h40, vec_of(0), "R7 priority 0 vector");
    reg_wr(8'h41, 32'h0);
    reg_wr(8'h41, 32'h0);
    int_src[0] = 1'b0;
    settle();

    // R8: edge-mode external line 3 (source 10)
    reg_wr(8'h0A, 32'h141);
    reg_rd(8'h0A, 32'h0000_0141, "R10 control readback");
    reg_wr(8'h03, 32'h121);
    reg_rd(8'h03, 32'h0000_0021, "R10 edge bit dropped on internal");
    @(negedge clk); ext_src[3] = 1'b1;
    repeat (2) @(negedge clk); ext_src[3] = 1'b0;
    settle();
    check({31'b0, irq}, 32'd1, "R8 edge latched");
    reg_rd(8'h42, 32'h0000_0400, "R11 latched edge pending");
    reg_rd(8'h40, vec_of(10), "R8 edge vector");
    settle();
    check({31'b0, irq}, 32'd0, "R8 edge acked");
    reg_wr(8'h41, 32'h0);
    settle();
    check({31'b0, irq}, 32'd0, "R8 edge cleared by read");

    // R9: fast line, level then edge
    reg_wr(8'h45, 32'h001);
    ext_src[0] = 1'b1;
    settle();
    check({31'b0, fiq}, 32'd1, "R9 fast level request");
    check({31'b0, irq}, 32'd0, "R9 fast not on normal output");
    reg_rd(8'h42, 32'h8000_0000, "R11 fast pending bit");
    reg_rd(8'h44, 32'h0000_0F00, "R9 fast vector");
    ext_src[0] = 1'b0;
    settle();
    check({31'b0, fiq}, 32'd0, "R9 fast level released");
    reg_wr(8'h45, 32'h101);
    @(negedge clk); ext_src[0] = 1'b1;
    repeat (2) @(negedge clk); ext_src[0] = 1'b0;
    settle();
    check({31'b0, fiq}, 32'd1, "R9 fast edge latched");
    reg_rd(8'h44, 32'h0000_0F00, "R9 fast vector edge");
    settle();
    check({31'b0, fiq}, 32'd0, "R9 fast edge cleared");

    settle();
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL missing read data actual=%0d expected=0 outstanding", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule